// File: doc/BRIEF.md
# Queue Doorbell Register Decoder

This block sits on the device side of a host-to-device queue interface. The host announces progress on its ring buffers with plain register writes into a doorbell window. Each queue owns two doorbells. The first carries the new submission tail and the second carries the new completion head. The spacing between doorbells is a programmable power of two. The block turns each write into a queue number and a doorbell kind, and keeps one submission tail and one completion head per queue.

The block keeps a fetch pointer for each submission ring, which a downstream fetch engine advances one entry per pulse. It flags every queue whose tail differs from that pointer. Writes that miss a doorbell or name a queue that does not exist are dropped and raise an address error. Pointer values outside the ring are also dropped and raise a value error. Queue 0 is the admin queue and I/O queues start at index 1. The number of queues and the largest ring depth are parameters.

Top module: `qdb_decoder`

## Requirements
- R1: After a synchronous active-high reset, every stored tail, head and fetch pointer is zero, no queue is flagged pending, and both error outputs are low.
- R2: A write to byte address 0x1000 + 2*q*(4 << stride_exp) stores wr_data as the submission tail of queue q, visible on sq_tail_o from the next cycle (queue q occupies bits q*PTR_W upward).
- R3: A write to byte address 0x1000 + (2*q+1)*(4 << stride_exp) stores wr_data as the completion head of queue q, visible on cq_head_o from the next cycle, and leaves every tail unchanged.
- R4: The doorbell spacing follows stride_exp, so that the same queue is reached at different addresses for exponents 0, 1 and 3, queue 0 (admin) included.
- R5: A write inside the window (address at or above 0x1000) whose offset from 0x1000 is not a multiple of 4 << stride_exp changes no pointer and raises err_addr_o for one cycle.
- R6: A write whose queue number is at or above q_count, or at or above NUM_Q, changes no pointer and raises err_addr_o for one cycle.
- R7: The ring depth is min(cap_mqes + 1, 2^PTR_W), with cap_mqes zero-based. A value at or above this depth is discarded and raises err_value_o for one cycle.
- R8: sq_pending_o[q] is high exactly when the tail of queue q differs from its fetch pointer. A pulse on fetch_inc[q] advances that pointer by one and wraps to 0 at the depth, but only while the queue is pending.
- R9: A write below 0x1000, or a cycle with wr_en low, changes no pointer and raises no error.
- R10: The error outputs are one-cycle pulses. They are low in any cycle that follows a cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | DATA_W | Write data (pointer value) |
| stride_exp | input | STRIDE_W | Doorbell spacing exponent; spacing is 4 << stride_exp bytes |
| q_count | input | QCNT_W | Number of queues currently configured |
| cap_mqes | input | 16 | Zero-based maximum queue entries |
| fetch_inc | input | NUM_Q | Per-queue pulse: one submission entry consumed |
| sq_tail_o | output | NUM_Q*PTR_W | Stored submission tails, packed by queue |
| cq_head_o | output | NUM_Q*PTR_W | Stored completion heads, packed by queue |
| sq_pending_o | output | NUM_Q | Queue has entries not yet fetched |
| err_addr_o | output | 1 | Pulse: write dropped for a bad address |
| err_value_o | output | 1 | Pulse: write dropped for an out-of-range value |

## Verification
Doorbell writes are made under three stride exponents, so that a decoder with a fixed spacing writes the wrong queue or the wrong kind. Offsets one doorbell apart, half a stride off, and queue numbers just past the configured count separate good writes from the two address failures. Values just below and just at the depth are tried with the maximum-entries field both above and below the parameter cap, which checks the clamp. Fetch pulses are given up to the tail, past the tail, and across a ring wrap, which checks the pending flag and the wrap point.

// File: rtl/qdb_pkg.sv
package qdb_pkg;
  typedef enum logic [1:0] {
    DB_NONE = 2'd0,
    DB_SQ   = 2'd1,
    DB_CQ   = 2'd2
  } db_kind_e;

  localparam int unsigned DB_BASE = 32'h1000;
endpackage

// File: rtl/qdb_addr_decode.sv
module qdb_addr_decode
  import qdb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_Q    = 8,
  parameter int STRIDE_W = 4,
  parameter int QCNT_W   = $clog2(NUM_Q + 1),
  parameter int QIDX_W   = $clog2(NUM_Q)
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic [STRIDE_W-1:0] stride_exp,
  input  logic [QCNT_W-1:0]   q_count,
  output db_kind_e            kind,
  output logic [QIDX_W-1:0]   qsel,
  output logic                in_region,
  output logic                addr_err
);
  localparam int SH_W = STRIDE_W + 1;

  logic [ADDR_W-1:0] off, idx, qn, low_mask;
  logic [SH_W-1:0]   sh;
  logic              aligned, q_ok;

  always_comb begin
    in_region = (addr >= ADDR_W'(DB_BASE));
    off       = addr - ADDR_W'(DB_BASE);
    sh        = {1'b0, stride_exp} + SH_W'(2);
    low_mask  = (ADDR_W'(1) << sh) - ADDR_W'(1);
    aligned   = ((off & low_mask) == '0);
    idx       = off >> sh;
    qn        = idx >> 1;
    q_ok      = (qn < ADDR_W'(q_count)) && (qn < ADDR_W'(NUM_Q));
    qsel      = qn[QIDX_W-1:0];
    addr_err  = in_region && !(aligned && q_ok);
    if (!in_region || addr_err) kind = DB_NONE;
    else if (idx[0])            kind = DB_CQ;
    else                        kind = DB_SQ;
  end
endmodule

// File: rtl/qdb_queue_regs.sv
module qdb_queue_regs #(
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sq_we,
  input  logic             cq_we,
  input  logic [PTR_W-1:0] wdata,
  input  logic             fetch_inc,
  input  logic [PTR_W:0]   limit,
  output logic [PTR_W-1:0] sq_tail,
  output logic [PTR_W-1:0] cq_head,
  output logic             pending
);
  logic [PTR_W-1:0] fetch_head;
  logic [PTR_W:0]   head_nxt;

  assign pending  = (sq_tail != fetch_head);
  assign head_nxt = {1'b0, fetch_head} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      sq_tail    <= '0;
      cq_head    <= '0;
      fetch_head <= '0;
    end else begin
      if (sq_we) sq_tail <= wdata;
      if (cq_we) cq_head <= wdata;
      if (fetch_inc && pending)
        fetch_head <= (head_nxt >= limit) ? '0 : head_nxt[PTR_W-1:0];
    end
  end

  // R8: the fetch pointer only moves while entries remain unfetched
  assert_fetch_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !pending |=> $stable(fetch_head));

  // R3: a completion-head update never disturbs the tail
  assert_cq_keeps_tail_R3: assert property (@(posedge clk) disable iff (rst)
    (cq_we && !sq_we) |=> $stable(sq_tail));
endmodule

// File: rtl/qdb_decoder.sv
module qdb_decoder
  import qdb_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int NUM_Q    = 8,
  parameter int PTR_W    = 6,
  parameter int STRIDE_W = 4,
  parameter int QCNT_W   = $clog2(NUM_Q + 1)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [STRIDE_W-1:0]    stride_exp,
  input  logic [QCNT_W-1:0]      q_count,
  input  logic [15:0]            cap_mqes,
  input  logic [NUM_Q-1:0]       fetch_inc,
  output logic [NUM_Q*PTR_W-1:0] sq_tail_o,
  output logic [NUM_Q*PTR_W-1:0] cq_head_o,
  output logic [NUM_Q-1:0]       sq_pending_o,
  output logic                   err_addr_o,
  output logic                   err_value_o
);
  localparam int QIDX_W = $clog2(NUM_Q);
  localparam logic [PTR_W:0] MAX_DEPTH = (PTR_W+1)'(1) << PTR_W;

  db_kind_e          kind;
  logic [QIDX_W-1:0] qsel;
  logic              in_region, addr_err, val_ok, accept;
  logic [16:0]       depth_raw;
  logic [PTR_W:0]    limit;

  qdb_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_Q(NUM_Q), .STRIDE_W(STRIDE_W),
    .QCNT_W(QCNT_W), .QIDX_W(QIDX_W)
  ) u_dec (
    .addr(wr_addr), .stride_exp(stride_exp), .q_count(q_count),
    .kind(kind), .qsel(qsel), .in_region(in_region), .addr_err(addr_err)
  );

  always_comb begin
    depth_raw = {1'b0, cap_mqes} + 17'd1;
    limit     = (depth_raw > 17'(MAX_DEPTH)) ? MAX_DEPTH : depth_raw[PTR_W:0];
    val_ok    = (wr_data < DATA_W'(limit));
    accept    = wr_en && (kind != DB_NONE) && val_ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_addr_o  <= 1'b0;
      err_value_o <= 1'b0;
    end else begin
      err_addr_o  <= wr_en && addr_err;
      err_value_o <= wr_en && (kind != DB_NONE) && !val_ok;
    end
  end

  for (genvar q = 0; q < NUM_Q; q++) begin : g_q
    logic sel;
    assign sel = (qsel == QIDX_W'(q));
    qdb_queue_regs #(.PTR_W(PTR_W)) u_regs (
      .clk(clk), .rst(rst),
      .sq_we(accept && sel && (kind == DB_SQ)),
      .cq_we(accept && sel && (kind == DB_CQ)),
      .wdata(wr_data[PTR_W-1:0]),
      .fetch_inc(fetch_inc[q]),
      .limit(limit),
      .sq_tail(sq_tail_o[q*PTR_W +: PTR_W]),
      .cq_head(cq_head_o[q*PTR_W +: PTR_W]),
      .pending(sq_pending_o[q])
    );
  end

  // R10: error pulses appear only after a write cycle
  assert_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> (!err_addr_o && !err_value_o));

  // R6 / R5: a rejected address leaves every stored pointer unchanged
  assert_ignore_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr_err) |=> ($stable(sq_tail_o) && $stable(cq_head_o)));

  // R7: an out-of-range value leaves every stored pointer unchanged
  assert_value_drop_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !val_ok) |=> ($stable(sq_tail_o) && $stable(cq_head_o)));

  // R5/R7: a single write never raises both errors
  assert_err_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(err_addr_o && err_value_o));
endmodule

// File: tb/qdb_decoder_test.sv
module qdb_decoder_test;
  localparam int NQ = 8, PW = 6, AW = 16, DW = 32;

  logic clk = 0, rst = 1, wr_en = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [3:0]    stride_exp = '0;
  logic [3:0]    q_count = 4'd8;
  logic [15:0]   cap_mqes = 16'd63;
  logic [NQ-1:0] fetch_inc = '0;
  logic [NQ*PW-1:0] sq_tail_o, cq_head_o;
  logic [NQ-1:0] sq_pending_o;
  logic err_addr_o, err_value_o;

  int checks = 0, errors = 0;
  int m_tail[NQ], m_head[NQ], m_fh[NQ];
  int m_ea = 0, m_ev = 0;

  always #5 clk = ~clk;

  qdb_decoder uut (.*);

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int q = 0; q < NQ; q++) begin m_tail[q] = 0; m_head[q] = 0; m_fh[q] = 0; end
      m_ea = 0; m_ev = 0;
    end else begin
      int lim, off, sh, idx, qn;
      lim = (cap_mqes + 1 > 64) ? 64 : cap_mqes + 1;
      m_ea = 0; m_ev = 0;
      for (int q = 0; q < NQ; q++)
        if (fetch_inc[q] && m_tail[q] != m_fh[q]) m_fh[q] = (m_fh[q] + 1) % lim;
      if (wr_en && wr_addr >= 16'h1000) begin
        off = wr_addr - 16'h1000;
        sh  = stride_exp + 2;
        idx = off >> sh;
        qn  = idx / 2;
        if ((off % (1 << sh)) != 0 || qn >= q_count || qn >= NQ) m_ea = 1;
        else if (wr_data >= lim) m_ev = 1;
        else if (idx % 2 == 0) m_tail[qn] = wr_data;
        else m_head[qn] = wr_data;
      end
    end
  end

  // cycle-by-cycle comparison away from the active edge
  always @(negedge clk) if (!rst) begin
    for (int q = 0; q < NQ; q++) begin
      chk(sq_tail_o[q*PW +: PW] == m_tail[q], "R2 tail", sq_tail_o[q*PW +: PW], m_tail[q]);
      chk(cq_head_o[q*PW +: PW] == m_head[q], "R3 head", cq_head_o[q*PW +: PW], m_head[q]);
      chk(sq_pending_o[q] == (m_tail[q] != m_fh[q]), "R8 pending",
          sq_pending_o[q], m_tail[q] != m_fh[q]);
    end
    chk(err_addr_o == m_ea, "R5/R6 err_addr", err_addr_o, m_ea);
    chk(err_value_o == m_ev, "R7 err_value", err_value_o, m_ev);
  end

  function automatic int tail(int q); return int'(sq_tail_o[q*PW +: PW]); endfunction
  function automatic int head(int q); return int'(cq_head_o[q*PW +: PW]); endfunction
  function automatic int dba(int q, int cq, int s); return 'h1000 + (2*q + cq) * (4 << s); endfunction

  task automatic wr(int a, int d);
    wr_en = 1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic fetch(int q, int n);
    for (int i = 0; i < n; i++) begin
      fetch_inc = NQ'(1) << q;
      @(negedge clk);
    end
    fetch_inc = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog expired: actual 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(sq_tail_o == '0 && cq_head_o == '0, "R1 pointers", int'(sq_tail_o[31:0]), 0);
    chk(sq_pending_o == '0 && !err_addr_o && !err_value_o, "R1 flags", sq_pending_o, 0);

    // R2 / R3 with stride exponent 0
    wr(dba(1, 0, 0), 5);
    chk(tail(1) == 5, "R2 sq tail q1", tail(1), 5);
    chk(sq_pending_o[1], "R8 pending set", sq_pending_o[1], 1);
    wr(dba(1, 1, 0), 3);
    chk(head(1) == 3 && tail(1) == 5, "R3 cq head q1", head(1), 3);
    // R4 admin queue at base
    wr('h1000, 7);
    chk(tail(0) == 7, "R4 admin tail", tail(0), 7);

    // R4 stride exponent 1
    stride_exp = 4'd1;
    wr(dba(2, 0, 1), 9);
    chk(tail(2) == 9, "R4 stride1 tail q2", tail(2), 9);
    wr(dba(2, 1, 1), 4);
    chk(head(2) == 4, "R4 stride1 head q2", head(2), 4);
    // R5 misaligned, one half stride in
    wr(dba(2, 0, 1) + 4, 11);
    chk(err_addr_o && tail(2) == 9 && head(2) == 4, "R5 misaligned", err_addr_o, 1);
    @(negedge clk);
    chk(!err_addr_o, "R10 pulse clears", err_addr_o, 0);

    // R4 stride exponent 3
    stride_exp = 4'd3;
    wr(dba(3, 0, 3), 12);
    chk(tail(3) == 12, "R4 stride3 tail q3", tail(3), 12);

    // R6 queue beyond configured count
    q_count = 4'd4;
    wr(dba(5, 0, 3), 2);
    chk(err_addr_o && tail(5) == 0, "R6 q beyond count", tail(5), 0);
    wr(dba(8, 1, 3), 2);
    chk(err_addr_o, "R6 q beyond NUM_Q", err_addr_o, 1);
    wr(dba(3, 1, 3), 6);
    chk(head(3) == 6 && !err_addr_o, "R6 last valid queue", head(3), 6);

    // R7 depth clamp, then a small depth
    cap_mqes = 16'd1000;
    wr(dba(3, 0, 3), 63);
    chk(tail(3) == 63 && !err_value_o, "R7 clamp accepts 63", tail(3), 63);
    wr(dba(3, 0, 3), 64);
    chk(err_value_o && tail(3) == 63, "R7 clamp rejects 64", tail(3), 63);
    cap_mqes = 16'd15;
    wr(dba(3, 1, 3), 16);
    chk(err_value_o && head(3) == 6, "R7 rejects depth", head(3), 6);
    wr(dba(3, 1, 3), 15);
    chk(head(3) == 15 && !err_value_o, "R7 accepts depth-1", head(3), 15);

    // R9 below region and strobe low
    wr(16'h0FFC, 1);
    chk(!err_addr_o && !err_value_o && tail(0) == 7, "R9 below window", tail(0), 7);
    wr_addr = AW'(dba(1, 0, 3)); wr_data = 1;
    @(negedge clk);
    chk(tail(1) == 5, "R9 strobe low", tail(1), 5);

    // R8 fetch to tail, past tail, across wrap
    fetch(1, 5);
    chk(!sq_pending_o[1], "R8 drained", sq_pending_o[1], 0);
    fetch(1, 2);
    chk(!sq_pending_o[1], "R8 extra fetch ignored", sq_pending_o[1], 0);
    wr(dba(1, 0, 3), 2);
    fetch(1, 12);
    chk(sq_pending_o[1], "R8 before wrap end", sq_pending_o[1], 1);
    fetch(1, 1);
    chk(!sq_pending_o[1], "R8 wrapped to tail", sq_pending_o[1], 0);

    // R1 reset again clears state
    rst = 1; @(negedge clk); rst = 0; @(negedge clk);
    chk(sq_tail_o == '0 && sq_pending_o == '0, "R1 re-reset", sq_pending_o, 0);

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule